// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block behaves as a 2048-byte serial EEPROM on a two-wire bus. Its storage is a register array inside the block. A host drives SCL and SDA, and the block samples both lines with its own system clock. It finds START and STOP conditions and checks the device-select byte. On a write it takes the word address and then up to a page of data. On a read it returns bytes one after another. It drives SDA only through an open-drain enable: while the enable is high the line is pulled low.

Write data goes into a page buffer first. The data reaches the array only when a STOP ends the transfer. A STOP after at least one data byte also starts an internal write cycle. That cycle lasts a set number of system clocks. While it runs, the slave ignores the bus completely. A host can therefore poll with device-select bytes until one is acknowledged, and so learn when the write has finished. The top three bits of the 11-bit address come from the device-select byte. The low eight bits come from the word-address byte.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset `sda_oe_o` is low, and the first valid device-select byte is acknowledged.
- R2: A device-select byte is acknowledged only when its bits [7:4] are 1010. Any other value gets no acknowledge, and the slave then ignores every bit until the next START or STOP.
- R3: The byte address is {select[3:1], word[7:0]}. Bit 0 of the select byte is 1 for a read and 0 for a write. Two locations that differ only in select[3:1] hold separate data.
- R4: A byte written with select, word address, one data byte and STOP reads back unchanged.
- R5: In a page write, address bits [3:0] count up and wrap within the 16-byte page, and bits [10:4] never change. A 17th byte overwrites the first byte of the page.
- R6: Write data reaches the array only at STOP. A repeated START drops the buffered bytes. A STOP that comes before any data byte starts no write cycle.
- R7: After a write STOP, the slave acknowledges nothing and never drives SDA for WRITE_CYCLES system clocks. After that it acknowledges a valid select byte again.
- R8: A sequential read returns bytes from consecutive addresses while the host acknowledges each byte. The address wraps from 0x7FF to 0x000.
- R9: When the host leaves SDA high in the acknowledge slot of a read, the slave releases SDA and keeps it released until the next START or STOP.
- R10: A STOP in the middle of any byte returns the slave to standby, and the next transaction is served normally.
- R11: `sda_oe_o` high means SDA is pulled to 0, and low means the line is released. The enable changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to sample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Resolved level of the data line |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
Some properties are checked on every cycle. The drive enable changes only while the synchronised SCL is low. The slave never drives while the write timer runs. The timer starts only on a STOP. The page bits of the address stay fixed during a write burst. An acknowledge is given only to a select byte with the right upper nibble. Other behaviour shows only in the bench's transactions: data landing at the 11-bit address, page wrap-around, dropping a write on a repeated START, wrap at the top of memory, NACK ending a read, and the timing of acknowledge polling.

// File: rtl/i2c_ee_pkg.sv
`timescale 1ns/1ps
package i2c_ee_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_ADDR, ST_ADDR_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RDATA_ACK, ST_WAIT, ST_BUSY
  } ee_state_e;
  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/i2c_ee_sync.sv
`timescale 1ns/1ps
module i2c_ee_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  // idle bus lines are high, so reset to ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/i2c_ee_cond.sv
`timescale 1ns/1ps
module i2c_ee_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  // SDA edge with SCL held high on both samples
  assign start_o = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o  = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/i2c_ee_busy.sv
`timescale 1ns/1ps
module i2c_ee_busy #(
  parameter int CYCLES = 5000,
  parameter int PAGE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  output logic              busy_o,
  output logic              commit_en_o,
  output logic [PAGE_W-1:0] commit_idx_o
);
  localparam int PAGE_N = 1 << PAGE_W;
  // the cycle must last long enough to drain the whole page buffer
  localparam int EFF    = (CYCLES < PAGE_N) ? PAGE_N : CYCLES;
  localparam int CNT_W  = $clog2(EFF + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt    <= '0;
      busy_o <= 1'b0;
    end else if (go_i) begin
      cnt    <= '0;
      busy_o <= 1'b1;
    end else if (busy_o) begin
      if (cnt == CNT_W'(EFF - 1)) busy_o <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end

  assign commit_en_o  = busy_o && (cnt < CNT_W'(PAGE_N));
  assign commit_idx_o = cnt[PAGE_W-1:0];
endmodule

// File: rtl/i2c_ee_mem.sv
`timescale 1ns/1ps
module i2c_ee_mem #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [7:0]               rd_data_o,
  input  logic                     buf_clr_i,
  input  logic                     buf_we_i,
  input  logic [PAGE_W-1:0]        buf_idx_i,
  input  logic [7:0]               buf_data_i,
  input  logic                     commit_en_i,
  input  logic [PAGE_W-1:0]        commit_idx_i,
  input  logic [ADDR_W-PAGE_W-1:0] page_i
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE_N = 1 << PAGE_W;

  logic [7:0]        mem   [DEPTH];
  logic [7:0]        pbuf  [PAGE_N];
  logic [PAGE_N-1:0] pvalid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pvalid <= '0;
      for (int i = 0; i < PAGE_N; i++) pbuf[i] <= '0;
    end else if (buf_clr_i) begin
      pvalid <= '0;
    end else if (buf_we_i) begin
      pbuf[buf_idx_i]   <= buf_data_i;
      pvalid[buf_idx_i] <= 1'b1;
    end
  end

  // one buffered byte is moved into the array per clock of the write cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit_en_i && pvalid[commit_idx_i]) begin
      mem[{page_i, commit_idx_i}] <= pbuf[commit_idx_i];
    end
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/i2c_eeprom_slave.sv
`timescale 1ns/1ps
module i2c_eeprom_slave
  import i2c_ee_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int PAGE_W       = 4,
  parameter int WRITE_CYCLES = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  localparam int HI_W = ADDR_W - 8;
  localparam int PG_W = ADDR_W - PAGE_W;

  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic busy, commit_en;
  logic [PAGE_W-1:0] commit_idx;
  logic [7:0] rd_data;

  ee_state_e         state;
  logic [7:0]        shreg, tx_sh;
  logic [2:0]        bit_cnt;
  logic              byte_done, dev_ok, rw_q, mst_ack, has_data, oe_q;
  logic [ADDR_W-1:0] addr_q;

  logic [7:0] rx_byte;
  logic       byte_end, wr_go, buf_we, buf_clr, in_wr, dev_ack_st;

  i2c_ee_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  i2c_ee_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (scl_s),
    .sda_s_i   (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  i2c_ee_busy #(.CYCLES(WRITE_CYCLES), .PAGE_W(PAGE_W)) u_busy (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (wr_go),
    .busy_o      (busy),
    .commit_en_o (commit_en),
    .commit_idx_o(commit_idx)
  );

  i2c_ee_mem #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_mem (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_addr_i   (addr_q),
    .rd_data_o   (rd_data),
    .buf_clr_i   (buf_clr),
    .buf_we_i    (buf_we),
    .buf_idx_i   (addr_q[PAGE_W-1:0]),
    .buf_data_i  (rx_byte),
    .commit_en_i (commit_en),
    .commit_idx_i(commit_idx),
    .page_i      (addr_q[ADDR_W-1:PAGE_W])
  );

  assign rx_byte    = {shreg[6:0], sda_s};
  assign byte_end   = scl_rise && (bit_cnt == 3'd7);
  assign in_wr      = (state == ST_WDATA) || (state == ST_WDATA_ACK);
  assign dev_ack_st = (state == ST_DEV_ACK);
  assign wr_go      = stop_det && in_wr && has_data;
  assign buf_clr    = start_det && (state != ST_BUSY);
  assign buf_we     = (state == ST_WDATA) && byte_end && !start_det && !stop_det;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      shreg     <= '0;
      tx_sh     <= '0;
      bit_cnt   <= '0;
      byte_done <= 1'b0;
      dev_ok    <= 1'b0;
      rw_q      <= 1'b0;
      mst_ack   <= 1'b0;
      has_data  <= 1'b0;
      oe_q      <= 1'b0;
      addr_q    <= '0;
    end else if (state == ST_BUSY) begin
      oe_q <= 1'b0;
      if (!busy) state <= ST_IDLE;
    end else if (start_det) begin
      state     <= ST_DEV;
      bit_cnt   <= '0;
      byte_done <= 1'b0;
      has_data  <= 1'b0;
      oe_q      <= 1'b0;
    end else if (stop_det) begin
      state     <= wr_go ? ST_BUSY : ST_IDLE;
      byte_done <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      unique case (state)
        ST_DEV, ST_ADDR, ST_WDATA: begin
          if (scl_rise) begin
            shreg   <= rx_byte;
            bit_cnt <= bit_cnt + 1'b1;
          end
          if (byte_end) begin
            byte_done <= 1'b1;
            if (state == ST_DEV) begin
              dev_ok <= (rx_byte[7:4] == DEV_CODE);
              rw_q   <= rx_byte[0];
              if (rx_byte[7:4] == DEV_CODE) addr_q[ADDR_W-1:8] <= rx_byte[HI_W:1];
            end else if (state == ST_ADDR) begin
              addr_q[7:0] <= rx_byte;
            end else begin
              addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + 1'b1;
              has_data           <= 1'b1;
            end
          end
          if (scl_fall && byte_done) begin
            byte_done <= 1'b0;
            if (state == ST_DEV) begin
              state <= dev_ok ? ST_DEV_ACK : ST_WAIT;
              oe_q  <= dev_ok;
            end else begin
              state <= (state == ST_ADDR) ? ST_ADDR_ACK : ST_WDATA_ACK;
              oe_q  <= 1'b1;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (rw_q) begin
              state  <= ST_RDATA;
              tx_sh  <= rd_data;
              oe_q   <= ~rd_data[7];
              addr_q <= addr_q + 1'b1;
            end else begin
              state <= ST_ADDR;
              oe_q  <= 1'b0;
            end
          end
        end
        ST_ADDR_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            state   <= ST_WDATA;
            bit_cnt <= '0;
            oe_q    <= 1'b0;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bit_cnt == 3'd7) begin
              state <= ST_RDATA_ACK;
              oe_q  <= 1'b0;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
              tx_sh   <= {tx_sh[6:0], 1'b0};
              oe_q    <= ~tx_sh[6];
            end
          end
        end
        ST_RDATA_ACK: begin
          if (scl_rise) mst_ack <= ~sda_s;
          if (scl_fall) begin
            if (mst_ack) begin
              state   <= ST_RDATA;
              bit_cnt <= '0;
              tx_sh   <= rd_data;
              oe_q    <= ~rd_data[7];
              addr_q  <= addr_q + 1'b1;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/i2c_ee_chk.sv
`timescale 1ns/1ps
module i2c_ee_chk #(
  parameter int PG_W = 7
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            scl_s_i,
  input logic            sda_oe_i,
  input logic            busy_i,
  input logic            stop_i,
  input logic            in_wr_i,
  input logic            dev_ack_i,
  input logic [3:0]      dev_nib_i,
  input logic [PG_W-1:0] page_i
);
  p_oe_scl_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_i) |-> !scl_s_i);

  p_quiet_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !sda_oe_i);

  p_busy_on_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(stop_i));

  p_page_fixed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_wr_i && $past(in_wr_i)) |-> (page_i == $past(page_i)));

  p_ack_code_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_ack_i && sda_oe_i) |-> (dev_nib_i == 4'b1010));
endmodule

bind i2c_eeprom_slave i2c_ee_chk #(.PG_W(ADDR_W - PAGE_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_s_i  (scl_s),
  .sda_oe_i (sda_oe_o),
  .busy_i   (busy),
  .stop_i   (stop_det),
  .in_wr_i  (in_wr),
  .dev_ack_i(dev_ack_st),
  .dev_nib_i(shreg[7:4]),
  .page_i   (addr_q[ADDR_W-1:PAGE_W])
);

// File: tb/i2c_eeprom_slave_tb.sv
`timescale 1ns/1ps
module i2c_eeprom_slave_tb;
  localparam int WC = 400;

  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1;
  logic sda_oe;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  i2c_eeprom_slave #(.WRITE_CYCLES(WC)) u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .scl_i   (scl_m),
    .sda_i   (sda_line),
    .sda_oe_o(sda_oe)
  );

  int    vecs = 0, fails = 0;
  bit    done = 0;
  bit    chk_en = 0;
  bit    exp_oe = 0;
  string cur_req = "R1";
  logic [7:0] model [2048];

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison of the drive enable during the SCL high phase (R11)
  always @(negedge clk) begin
    if (chk_en && !done) begin
      vecs++;
      if (sda_oe !== exp_oe) begin
        fails++;
        $display("FAIL %s oe act=%0b exp=%0b", cur_req, sda_oe, exp_oe);
      end
    end
  end

  task automatic clk_bit(bit b, bit e_oe, output bit seen);
    tick(4); sda_m = b;
    tick(4); scl_m = 1;
    tick(3); exp_oe = e_oe; chk_en = 1;
    tick(4); seen = sda_line; chk_en = 0;
    tick(1); scl_m = 0;
  endtask

  task automatic i2c_start();
    tick(4); sda_m = 1;
    tick(4); scl_m = 1;
    tick(6); sda_m = 0;
    tick(6); scl_m = 0;
  endtask

  task automatic i2c_stop();
    tick(4); sda_m = 0;
    tick(4); scl_m = 1;
    tick(6); sda_m = 1;
    tick(6);
  endtask

  task automatic send_byte(logic [7:0] b, bit exp_ack, string req);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], 1'b0, s);
    clk_bit(1'b1, exp_ack, s);
    chk(s == !exp_ack, req, s, !exp_ack);
  endtask

  task automatic read_byte(logic [7:0] exp, bit m_ack, string req);
    bit s;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, ~exp[i], s);
      got[i] = s;
    end
    clk_bit(!m_ack, 1'b0, s);
    chk(got == exp, req, got, exp);
  endtask

  function automatic logic [7:0] dev_of(int a, bit rd);
    return 8'hA0 | 8'((a >> 8) & 7) << 1 | 8'(rd);
  endfunction

  task automatic ee_write(int a, logic [7:0] d [$], string req);
    cur_req = req;
    i2c_start();
    send_byte(dev_of(a, 0), 1, req);
    send_byte(8'(a), 1, req);
    foreach (d[i]) begin
      send_byte(d[i], 1, req);
      model[(a & 'h7F0) | ((a + i) & 'hF)] = d[i];
    end
    i2c_stop();
  endtask

  task automatic ee_read(int a, int n, string req);
    cur_req = req;
    i2c_start();
    send_byte(dev_of(a, 0), 1, req);
    send_byte(8'(a), 1, req);
    i2c_start();
    send_byte(dev_of(a, 1), 1, req);
    for (int i = 0; i < n; i++) read_byte(model[(a + i) & 'h7FF], i < n - 1, req);
    i2c_stop();
  endtask

  task automatic summary();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
  end

  initial begin
    logic [7:0] q [$];
    bit s;
    for (int i = 0; i < 2048; i++) model[i] = 8'h00;
    tick(5);
    rst_n = 1;
    tick(5);
    chk(sda_oe == 1'b0, "R1", sda_oe, 0);

    // R1, R4, R7: byte write, poll during busy (NACK), later poll ACK
    q = {8'h96};
    ee_write('h123, q, "R4");
    cur_req = "R7";
    i2c_start(); send_byte(8'hA0, 0, "R7"); i2c_stop();
    tick(WC + 100);
    i2c_start(); send_byte(8'hA0, 1, "R7"); i2c_stop();
    ee_read('h123, 1, "R4");
    ee_read('h023, 1, "R3");   // R3: same word byte, other select bits

    // R5: 18-byte page write starting at offset 0xE, wraps inside the page
    q = {};
    for (int i = 0; i < 18; i++) q.push_back(8'(8'h40 + i));
    ee_write('h3AE, q, "R5");
    tick(WC + 100);
    ee_read('h3A0, 17, "R5");

    // R6: repeated START drops buffered data, no write cycle follows
    cur_req = "R6";
    i2c_start();
    send_byte(8'hA0, 1, "R6"); send_byte(8'h10, 1, "R6"); send_byte(8'h55, 1, "R6");
    i2c_start();
    send_byte(8'hA1, 1, "R6");
    read_byte(8'h00, 0, "R6");
    i2c_stop();
    ee_read('h010, 1, "R6");
    // R6: STOP before any data byte -> immediate acknowledge
    i2c_start(); send_byte(8'hA4, 1, "R6"); send_byte(8'h77, 1, "R6"); i2c_stop();
    i2c_start(); send_byte(8'hA4, 1, "R6"); i2c_stop();

    // R8: sequential read wraps from 0x7FF to 0x000
    q = {8'hC3}; ee_write('h7FF, q, "R8"); tick(WC + 100);
    q = {8'h3C}; ee_write('h000, q, "R8"); tick(WC + 100);
    ee_read('h7FE, 3, "R8");

    // R2: wrong code gets no ACK, following bytes ignored
    cur_req = "R2";
    i2c_start();
    send_byte(8'h50, 0, "R2");
    send_byte(8'hA0, 0, "R2");
    i2c_stop();
    i2c_start(); send_byte(8'hB0, 0, "R2"); i2c_stop();

    // R9: host NACK ends the read; slave stays released
    cur_req = "R9";
    i2c_start();
    send_byte(8'hA2, 1, "R9"); send_byte(8'h23, 1, "R9");
    i2c_start();
    send_byte(8'hA3, 1, "R9");
    read_byte(model['h123], 0, "R9");
    send_byte(8'h00, 0, "R9");
    i2c_stop();

    // R10: STOP in the middle of the word-address byte
    cur_req = "R10";
    i2c_start();
    send_byte(8'hA2, 1, "R10");
    for (int i = 0; i < 4; i++) clk_bit(1'b0, 1'b0, s);
    i2c_stop();
    ee_read('h123, 1, "R10");

    tick(20);
    summary();
  end
endmodule